// File: doc/BRIEF.md
# Doorbell MSI Interrupt Controller

This block is a per-CPU doorbell unit. It turns memory-mapped writes into interrupt events. A bus-side port takes writes that have already been decoded to the software-trigger register, as a PCIe MSI write would arrive. The low byte of the write data names one doorbell bit in a 32-bit cause register, and that bit is set. The upper sixteen doorbells carry MSI vectors, and the lowest eight carry inter-processor interrupts.

A CPU-side port holds the doorbell enable mask. It clears pending causes by writing zeros to the bits to be dropped. It opens or closes a summary mask that gates all doorbell events on their way to the CPU. The CPU reads the cause register, the mask register and an acknowledge identifier. Identifier 0 reports a pending inter-processor doorbell. Identifier 1 reports a pending MSI doorbell. Identifier 1023 means that nothing is pending.

Top module: `doorbell_msi_ctrl`

## Requirements
- R1: After reset the cause and mask registers read 0, the summary mask is closed, the acknowledge read returns 1023, and irq_out, msi_irq and ipi_irq are all low.
- R2: A trigger write sets the cause bit whose number is bus_wr_data[7:0] when that number is below 32, and the bit is visible from the next cycle. An MSI for vector n is data 0xF00 | (n+16), and it sets bit n+16. No cause bit is set without a trigger write.
- R3: A trigger write whose doorbell number (bus_wr_data[7:0]) is 32 or more leaves the cause register unchanged.
- R4: A CPU write with cpu_wr_sel=0 clears every cause bit written as 0 and keeps every bit written as 1. Writing 0x0000FFFF clears all MSI bits (31:16) and keeps the IPI bits pending.
- R5: A CPU write with cpu_wr_sel=1 replaces the mask register. msi_irq is high when some bit in 31:16 is set in both the cause and mask registers. ipi_irq is the same for bits 7:0. Bits 15:8 drive neither line.
- R6: A CPU write with cpu_wr_sel=2 and data bit 0 set opens the summary mask. A write with cpu_wr_sel=3 and data bit 0 set closes it. irq_out is high when the summary mask is open and msi_irq or ipi_irq is high.
- R7: The acknowledge read returns 0 when irq_out is high and ipi_irq is high. It returns 1 when irq_out is high and only msi_irq is high. It returns 1023 otherwise.
- R8: A trigger write and a cause-clear write that hit the same bit in the same cycle leave that bit set.
- R9: cpu_rd_sel selects the combinational read data: 0 gives the cause register, 1 the mask register, 2 the acknowledge identifier, and 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Trigger-register write strobe |
| bus_wr_data | input | 32 | Trigger write data; bits 7:0 give the doorbell number |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_sel | input | 2 | 0 cause clear, 1 mask, 2 summary open, 3 summary close |
| cpu_wr_data | input | 32 | CPU write data |
| cpu_rd_sel | input | 2 | 0 cause, 1 mask, 2 acknowledge, 3 zero |
| cpu_rd_data | output | 32 | Read data for the selected register |
| msi_irq | output | 1 | Masked MSI group pending |
| ipi_irq | output | 1 | Masked IPI group pending |
| irq_out | output | 1 | Doorbell interrupt to the CPU after the summary mask |

## Verification
The properties assume that the strobes are free of X and that reset is held low from time zero until the first clock edges have passed. They also assume that the data buses are stable whenever a strobe is high. The stimulus drives every input on the falling edge and holds a strobe for exactly one rising edge. It starts with reset low and uses doorbell numbers both inside and outside the 32-bit range. One case drives a trigger and a clear of the same bit in the same cycle, so the race property is exercised on purpose.

// File: rtl/doorbell_msi_ctrl.sv
module doorbell_msi_ctrl #(
  parameter int DB_W    = 32,
  parameter int NUM_W   = 8,
  parameter int IPI_N   = 8,
  parameter int MSI_LO  = 16,
  parameter int MSI_N   = 16,
  parameter int SPUR_ID = 1023
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr_en,
  input  logic [DB_W-1:0] bus_wr_data,
  input  logic            cpu_wr_en,
  input  logic [1:0]      cpu_wr_sel,
  input  logic [DB_W-1:0] cpu_wr_data,
  input  logic [1:0]      cpu_rd_sel,
  output logic [DB_W-1:0] cpu_rd_data,
  output logic            msi_irq,
  output logic            ipi_irq,
  output logic            irq_out
);
  localparam int IDX_W = $clog2(DB_W);
  localparam logic [DB_W-1:0] MSI_GRP = DB_W'({MSI_N{1'b1}}) << MSI_LO;
  localparam logic [DB_W-1:0] IPI_GRP = DB_W'({IPI_N{1'b1}});

  logic [DB_W-1:0] cause_q, mask_q, trig_vec;
  logic            sum_masked_q;
  logic [DB_W-1:0] ack_id;
  logic [NUM_W-1:0] db_num;
  logic            unused_hi;

  assign db_num    = bus_wr_data[NUM_W-1:0];
  assign unused_hi = ^bus_wr_data[DB_W-1:NUM_W];

  always_comb begin
    trig_vec = '0;
    if (bus_wr_en && (32'(db_num) < DB_W))
      trig_vec[db_num[IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q      <= '0;
      mask_q       <= '0;
      sum_masked_q <= 1'b1;
    end else begin
      if (cpu_wr_en && cpu_wr_sel == 2'd0)
        cause_q <= (cause_q & cpu_wr_data) | trig_vec;
      else
        cause_q <= cause_q | trig_vec;
      if (cpu_wr_en && cpu_wr_sel == 2'd1)
        mask_q <= cpu_wr_data;
      if (cpu_wr_en && cpu_wr_sel == 2'd2 && cpu_wr_data[0])
        sum_masked_q <= 1'b0;
      else if (cpu_wr_en && cpu_wr_sel == 2'd3 && cpu_wr_data[0])
        sum_masked_q <= 1'b1;
    end
  end

  assign msi_irq = |(cause_q & mask_q & MSI_GRP);
  assign ipi_irq = |(cause_q & mask_q & IPI_GRP);
  assign irq_out = !sum_masked_q && (msi_irq || ipi_irq);

  always_comb begin
    if (irq_out && ipi_irq)      ack_id = DB_W'(0);
    else if (irq_out)            ack_id = DB_W'(1);
    else                         ack_id = DB_W'(SPUR_ID);
  end

  always_comb begin
    case (cpu_rd_sel)
      2'd0:    cpu_rd_data = cause_q;
      2'd1:    cpu_rd_data = mask_q;
      2'd2:    cpu_rd_data = ack_id;
      default: cpu_rd_data = '0;
    endcase
  end
endmodule

module doorbell_msi_ctrl_chk #(
  parameter int DB_W    = 32,
  parameter int NUM_W   = 8,
  parameter int SPUR_ID = 1023
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr_en,
  input logic [DB_W-1:0] bus_wr_data,
  input logic            cpu_wr_en,
  input logic [1:0]      cpu_wr_sel,
  input logic [DB_W-1:0] cpu_wr_data,
  input logic [DB_W-1:0] cause_q,
  input logic [DB_W-1:0] ack_id,
  input logic            ipi_irq,
  input logic            irq_out
);
  localparam int IDX_W = $clog2(DB_W);
  logic in_rng, clr_wr;
  logic [IDX_W-1:0] idx;
  assign in_rng = 32'(bus_wr_data[NUM_W-1:0]) < DB_W;
  assign idx    = bus_wr_data[IDX_W-1:0];
  assign clr_wr = cpu_wr_en && cpu_wr_sel == 2'd0;

  p_trig_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && in_rng) |=> cause_q[$past(idx)]);
  p_no_spont_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> ((cause_q & ~$past(cause_q)) == '0));
  p_oor_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !in_rng && !clr_wr) |=> $stable(cause_q));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !bus_wr_en) |=> (cause_q == ($past(cause_q) & $past(cpu_wr_data))));
  p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (ack_id == DB_W'(SPUR_ID)));
  p_ipi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && ipi_irq) |-> (ack_id == '0));
  p_race_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && in_rng && clr_wr) |=> cause_q[$past(idx)]);
endmodule

bind doorbell_msi_ctrl doorbell_msi_ctrl_chk #(
  .DB_W(DB_W), .NUM_W(NUM_W), .SPUR_ID(SPUR_ID)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
  .cpu_wr_en(cpu_wr_en), .cpu_wr_sel(cpu_wr_sel), .cpu_wr_data(cpu_wr_data),
  .cause_q(cause_q), .ack_id(ack_id), .ipi_irq(ipi_irq), .irq_out(irq_out)
);

// File: tb/doorbell_msi_ctrl_tb_top.sv
module doorbell_msi_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic cpu_wr_en = 1'b0;
  logic [1:0] cpu_wr_sel = '0;
  logic [31:0] cpu_wr_data = '0;
  logic [1:0] cpu_rd_sel = '0;
  logic [31:0] cpu_rd_data;
  logic msi_irq, ipi_irq, irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  ev_chk;

  always #2 clk = ~clk;

  doorbell_msi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_sel(cpu_wr_sel), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_sel(cpu_rd_sel), .cpu_rd_data(cpu_rd_data),
    .msi_irq(msi_irq), .ipi_irq(ipi_irq), .irq_out(irq_out)
  );

  initial begin
    forever begin
      @(ev_chk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {29'd0, irq_out, msi_irq, ipi_irq} : cpu_rd_data;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [1:0] sel, input logic [31:0] e, input string tag);
    cpu_rd_sel = sel;
    sb_q.push_back('{1'b0, e, tag});
    -> ev_chk;
    #2;
  endtask

  task automatic exp_irq(input logic [2:0] e, input string tag);
    sb_q.push_back('{1'b1, {29'd0, e}, tag});
    -> ev_chk;
    #2;
  endtask

  task automatic bus_wr(input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_wr_data = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic cpu_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_sel = sel; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_rd(2'd0, 32'h0, "R1 cause after reset");
    exp_rd(2'd1, 32'h0, "R1 mask after reset");
    exp_rd(2'd2, 32'd1023, "R1 ack after reset");
    exp_irq(3'b000, "R1 irq lines after reset");

    bus_wr(32'h0000_0F10);
    exp_rd(2'd0, 32'h0001_0000, "R2 msi vector 0 sets bit 16");
    exp_irq(3'b000, "R5 unmasked cause gives no msi_irq");

    cpu_wr(2'd1, 32'hFFFF_0000);
    exp_rd(2'd1, 32'hFFFF_0000, "R5 mask write replaces");
    exp_irq(3'b010, "R6 msi_irq but summary closed");
    exp_rd(2'd2, 32'd1023, "R7 ack while summary closed");

    cpu_wr(2'd2, 32'h1);
    exp_irq(3'b110, "R6 summary opened");
    exp_rd(2'd2, 32'd1, "R7 ack msi id");

    bus_wr(32'h0000_0003);
    cpu_wr(2'd1, 32'hFFFF_00FF);
    exp_irq(3'b111, "R5 ipi line");
    exp_rd(2'd2, 32'd0, "R7 ipi before msi");

    bus_wr(32'h0000_0F20);
    exp_rd(2'd0, 32'h0001_0008, "R3 number 32 ignored");
    bus_wr(32'h0000_00FF);
    exp_rd(2'd0, 32'h0001_0008, "R3 number 255 ignored");

    bus_wr(32'h0000_0F1F);
    exp_rd(2'd0, 32'h8001_0008, "R2 msi vector 15 sets bit 31");

    cpu_wr(2'd0, 32'h0000_0008);
    bus_wr(32'h0000_000A);
    exp_rd(2'd0, 32'h0000_0408, "R2 bit 10 set");
    exp_irq(3'b101, "R5 bits 15:8 drive no line");

    bus_wr(32'h0000_0F10);
    cpu_wr(2'd0, 32'h0000_FFFF);
    exp_rd(2'd0, 32'h0000_0408, "R4 msi group cleared, ipi kept");
    exp_irq(3'b101, "R4 msi line low after clear");

    bus_wr(32'h0000_0011);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_wr_data = 32'h0000_0011;
    cpu_wr_en = 1'b1; cpu_wr_sel = 2'd0; cpu_wr_data = 32'h0;
    @(negedge clk);
    bus_wr_en = 1'b0; cpu_wr_en = 1'b0;
    exp_rd(2'd0, 32'h0002_0000, "R8 trigger wins over same-cycle clear");

    exp_rd(2'd3, 32'h0, "R9 select 3 reads zero");

    cpu_wr(2'd3, 32'h1);
    exp_irq(3'b010, "R6 summary closed again");
    exp_rd(2'd2, 32'd1023, "R7 ack after summary close");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_rd(2'd0, 32'h0, "R1 cause after second reset");
    exp_rd(2'd1, 32'h0, "R1 mask after second reset");

    #10;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule